// File: doc/BRIEF.md
# Boolean-Controlled Two-Way Merge

This block merges two data streams under the direction of a third stream of single-bit steering tokens. Each operation starts by taking one steering token. A zero names the "false" data lane and a one names the "true" data lane. The block then takes exactly one word from the named lane and presents it on its single output. The other lane is never touched. Words queued there stay in place for later operations that name that lane.

All four streams use a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high.

The block moves through three modes:

- **Steering:** it waits for a steering token.
- **Fetch:** it waits for a word on the named lane.
- **Emit:** it holds the output word until downstream accepts it.

It asserts ready on an input only in the mode that consumes from that input, and only once the inputs that mode needs can be taken. The steering value stays latched until the output word it chose has left the block.

Top module: `bool_select`

## Requirements
- R1: While reset is held and on the first clock after its release, `out_valid` is 0, `ctl_ready` is 1, and both `f_ready` and `t_ready` are 0.
- R2: Exactly one steering token is consumed per operation. `ctl_ready` is low from the edge that takes a steering token until the edge where the output word leaves, so `ctl_ready` and `out_valid` are never high together.
- R3: A steering value of 0 takes exactly one word from the false lane (`f_*`) and none from the true lane.
- R4: A steering value of 1 takes exactly one word from the true lane (`t_*`) and none from the false lane.
- R5: `f_ready` and `t_ready` are never high in the same cycle. The lane that was not named sees ready low throughout the operation, so its pending word is preserved.
- R6: Each operation produces exactly one output word, equal to the word taken from the named lane. Output order follows steering-token order.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the following cycle.
- R8: Neither data lane is offered ready while `ctl_ready` is high. A data word is never taken before its steering token.
- R9: A data word taken on clock edge n appears on `out_data` with `out_valid` high right after edge n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid | input | 1 | Steering token present |
| ctl_ready | output | 1 | Block will take a steering token |
| ctl_value | input | 1 | Steering value: 0 = false lane, 1 = true lane |
| f_valid | input | 1 | False-lane word present |
| f_ready | output | 1 | Block takes the false-lane word |
| f_data | input | DATA_W | False-lane word |
| t_valid | input | 1 | True-lane word present |
| t_ready | output | 1 | Block takes the true-lane word |
| t_data | input | DATA_W | True-lane word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | DATA_W | Output word |

## Verification
The steering stream is tried in three patterns:

- **Long runs of equal values:** this separates a block that correctly drains one lane repeatedly from one that alternates lanes by itself.
- **Strict alternation:** this exposes any lane latch that is not reloaded on every operation.
- **Random sequence:** this mixes the two behaviours.

All three data streams and the output see random stalls. The stalls keep some words waiting on the unnamed lane and hold the output back, which tests the preservation and hold rules. At the end, one extra word is left valid on each lane. The bench confirms that neither extra word was taken, and that each lane gave up exactly as many words as the steering stream named it.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    typedef enum logic [1:0] {
        M_STEER = 2'd0,
        M_FETCH = 2'd1,
        M_EMIT  = 2'd2
    } mode_e;

    localparam int unsigned LANES = 2;
    localparam int unsigned LANE_FALSE = 0;
    localparam int unsigned LANE_TRUE = 1;

    typedef struct packed {
        mode_e mode;
        logic  sel;
    } fsm_s;

endpackage

// File: rtl/bsel_mode_fsm.sv
module bsel_mode_fsm
    import bsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ctl_valid,
    input  logic  ctl_value,
    input  logic  data_fire,
    input  logic  out_fire,
    output logic  ctl_ready,
    output mode_e mode,
    output logic  sel
);

    fsm_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        ctl_ready = (st_q.mode == M_STEER);
        unique case (st_q.mode)
            M_STEER: begin
                if (ctl_valid) begin
                    st_d.sel  = ctl_value;
                    st_d.mode = M_FETCH;
                end
            end
            M_FETCH: begin
                if (data_fire) begin
                    st_d.mode = M_EMIT;
                end
            end
            M_EMIT: begin
                if (out_fire) begin
                    st_d.mode = M_STEER;
                end
            end
            default: st_d.mode = M_STEER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: M_STEER, sel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign sel  = st_q.sel;

    // R2: the latched steering value only changes while waiting for a token
    p_sel_held_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode != M_STEER) |=> $stable(st_q.sel));

    // R2: a fetched word always leads to an emit phase
    p_fetch_to_emit_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_FETCH && data_fire) |=> (st_q.mode == M_EMIT));

endmodule

// File: rtl/bsel_lane_route.sv
module bsel_lane_route
    import bsel_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              sel,
    input  logic              f_valid,
    input  logic [DATA_W-1:0] f_data,
    input  logic              t_valid,
    input  logic [DATA_W-1:0] t_data,
    output logic              f_ready,
    output logic              t_ready,
    output logic              data_fire,
    output logic [DATA_W-1:0] data_word
);

    logic [LANES-1:0]             lane_valid;
    logic [LANES-1:0]             lane_ready;
    logic [LANES-1:0][DATA_W-1:0] lane_data;

    assign lane_valid[LANE_FALSE] = f_valid;
    assign lane_valid[LANE_TRUE]  = t_valid;
    assign lane_data[LANE_FALSE]  = f_data;
    assign lane_data[LANE_TRUE]   = t_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic LANE_CODE = (g == LANE_TRUE);
        assign lane_ready[g] = (mode == M_FETCH) && (sel == LANE_CODE);
    end

    assign f_ready   = lane_ready[LANE_FALSE];
    assign t_ready   = lane_ready[LANE_TRUE];
    assign data_fire = |(lane_ready & lane_valid);
    assign data_word = lane_data[sel];

    // R5: never offer ready on both lanes
    p_single_lane_r5: assert property (@(posedge clk) disable iff (rst)
        !(f_ready && t_ready));

    // R3/R4: the offered lane matches the latched steering value
    p_lane_matches_r3: assert property (@(posedge clk) disable iff (rst)
        f_ready |-> (sel == 1'b0));
    p_lane_matches_r4: assert property (@(posedge clk) disable iff (rst)
        t_ready |-> (sel == 1'b1));

endmodule

// File: rtl/bsel_out_stage.sv
module bsel_out_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fire
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_s;

    slot_s slot_d, slot_q;

    always_comb begin
        slot_d   = slot_q;
        out_fire = slot_q.vld && out_ready;
        if (out_fire) begin
            slot_d.vld = 1'b0;
        end
        if (load) begin
            slot_d.vld = 1'b1;
            slot_d.dat = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.vld;
    assign out_data  = slot_q.dat;

    // R7: a stalled word holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: never overwrite a pending word
    p_no_overwrite_r6: assert property (@(posedge clk) disable iff (rst)
        load |-> !out_valid);

    // R9: a loaded word shows up on the next cycle
    p_load_latency_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> out_valid);

endmodule

// File: rtl/bool_select.sv
module bool_select
    import bsel_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_valid,
    output logic              ctl_ready,
    input  logic              ctl_value,
    input  logic              f_valid,
    output logic              f_ready,
    input  logic [DATA_W-1:0] f_data,
    input  logic              t_valid,
    output logic              t_ready,
    input  logic [DATA_W-1:0] t_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    mode_e             mode;
    logic              sel;
    logic              data_fire;
    logic              out_fire;
    logic [DATA_W-1:0] data_word;

    bsel_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_valid (ctl_valid),
        .ctl_value (ctl_value),
        .data_fire (data_fire),
        .out_fire  (out_fire),
        .ctl_ready (ctl_ready),
        .mode      (mode),
        .sel       (sel)
    );

    bsel_lane_route #(.DATA_W(DATA_W)) u_route (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .sel       (sel),
        .f_valid   (f_valid),
        .f_data    (f_data),
        .t_valid   (t_valid),
        .t_data    (t_data),
        .f_ready   (f_ready),
        .t_ready   (t_ready),
        .data_fire (data_fire),
        .data_word (data_word)
    );

    bsel_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (data_fire),
        .load_data (data_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_fire  (out_fire)
    );

    // R2: steering intake and a pending output never overlap
    p_ctl_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(ctl_ready && out_valid));

    // R8: no data lane is offered while a steering token is awaited
    p_no_early_data_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_ready |-> !(f_ready || t_ready));

    // R2: a taken steering token drops ctl_ready on the next cycle
    p_ctl_once_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready) |=> !ctl_ready);

endmodule

// File: tb/test_bool_select.sv
module test_bool_select;

    localparam int W = 16;
    localparam int N = 72;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         ctl_valid = 1'b0, ctl_value = 1'b0, ctl_ready;
    logic         f_valid = 1'b0, f_ready;
    logic         t_valid = 1'b0, t_ready;
    logic [W-1:0] f_data = '0, t_data = '0;
    logic         out_valid, out_ready = 1'b0;
    logic [W-1:0] out_data;

    bool_select #(.DATA_W(W)) i_bool_select (
        .clk(clk), .rst(rst),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_value(ctl_value),
        .f_valid(f_valid), .f_ready(f_ready), .f_data(f_data),
        .t_valid(t_valid), .t_ready(t_ready), .t_data(t_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int           n_cmp = 0, n_bad = 0;
    logic [W-1:0] exp_q[$];
    bit           ctl_list[N];
    int           nf = 0, nt = 0, f_acc = 0, t_acc = 0, outs = 0;
    bit           monitor_on = 1'b0, summary_done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver side: computes the expected output order from the steering list
    task automatic push_expected();
        int fi = 0, ti = 0;
        for (int k = 0; k < N; k++) begin
            if (ctl_list[k]) begin
                exp_q.push_back(W'(16'h2000 + ti));
                ti++;
            end else begin
                exp_q.push_back(W'(16'h1000 + fi));
                fi++;
            end
        end
        nf = fi;
        nt = ti;
    endtask

    task automatic stall(input int lane);
        int c = $urandom_range(0, 3);
        for (int s = 0; s < c; s++) begin
            case (lane)
                0: f_valid = 1'b0;
                1: t_valid = 1'b0;
                default: ctl_valid = 1'b0;
            endcase
            @(posedge clk); #2;
        end
    endtask

    task automatic send_lane(input int lane, input int cnt);
        bit ok;
        for (int i = 0; i < cnt; i++) begin
            stall(lane);
            case (lane)
                0: begin f_valid = 1'b1; f_data = W'(16'h1000 + i); end
                1: begin t_valid = 1'b1; t_data = W'(16'h2000 + i); end
                default: begin ctl_valid = 1'b1; ctl_value = ctl_list[i]; end
            endcase
            ok = 1'b0;
            while (!ok) begin
                @(negedge clk);
                case (lane)
                    0: ok = f_ready;
                    1: ok = t_ready;
                    default: ok = ctl_ready;
                endcase
                @(posedge clk); #2;
            end
        end
        // a final word stays pending on each data lane and must never be taken
        case (lane)
            0: begin f_valid = 1'b1; f_data = 16'h1FFF; end
            1: begin t_valid = 1'b1; t_data = 16'h2FFF; end
            default: ctl_valid = 1'b0;
        endcase
    endtask

    // monitor and scoreboard
    bit           last_ctl = 1'b0;
    bit           prev_stall = 1'b0;
    logic [W-1:0] prev_out = '0;
    bit           prev_dfire = 1'b0;
    logic [W-1:0] prev_word = '0;

    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            chk(!(f_ready && t_ready), "R5 both lanes ready", {14'd0, f_ready, t_ready}, 16'h0);
            chk(!(ctl_ready && out_valid), "R2 steering while output pending", {15'd0, out_valid}, 16'h0);
            chk(!(ctl_ready && (f_ready || t_ready)), "R8 data ready before steering", {14'd0, f_ready, t_ready}, 16'h0);
            if (f_ready) chk(last_ctl == 1'b0, "R3 false lane offered for true token", W'(last_ctl), 16'h0);
            if (t_ready) chk(last_ctl == 1'b1, "R4 true lane offered for false token", W'(last_ctl), 16'h1);
            if (prev_stall) chk(out_valid && out_data == prev_out, "R7 stalled word changed", out_data, prev_out);
            if (prev_dfire) chk(out_valid && out_data == prev_word, "R9 fetched word not on output", out_data, prev_word);

            prev_dfire = 1'b0;
            if (f_valid && f_ready) begin f_acc++; prev_dfire = 1'b1; prev_word = f_data; end
            if (t_valid && t_ready) begin t_acc++; prev_dfire = 1'b1; prev_word = t_data; end
            if (ctl_valid && ctl_ready) last_ctl = ctl_value;
            if (out_valid && out_ready) begin
                outs++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 extra output", out_data, 16'hxxxx);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R6 output order", out_data, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = out_data;
        end
    end

    always begin
        @(posedge clk); #2;
        if (!rst) out_ready = ($urandom_range(0, 3) != 0);
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "watchdog expired", W'(outs), W'(N));
        finish_run();
    end

    initial begin
        void'($urandom(7));
        for (int k = 0; k < N; k++) begin
            if (k < 12)      ctl_list[k] = (k / 6) == 0;
            else if (k < 36) ctl_list[k] = k[0];
            else             ctl_list[k] = $urandom_range(0, 1) == 1;
        end
        push_expected();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ctl_ready == 1'b1 && out_valid == 1'b0, "R1 reset state ctl/out", {14'd0, ctl_ready, out_valid}, 16'h2);
        chk(!f_ready && !t_ready, "R1 reset state lanes", {14'd0, f_ready, t_ready}, 16'h0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        chk(ctl_ready == 1'b1 && out_valid == 1'b0 && !f_ready && !t_ready, "R1 after release",
            {12'd0, ctl_ready, out_valid, f_ready, t_ready}, 16'h8);
        @(posedge clk); #2;
        monitor_on = 1'b1;

        fork
            send_lane(2, N);
            send_lane(0, nf);
            send_lane(1, nt);
        join_none

        while (outs < N) @(posedge clk);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(f_acc == nf, "R3 false-lane word count", W'(f_acc), W'(nf));
        chk(t_acc == nt, "R4 true-lane word count", W'(t_acc), W'(nt));
        chk(f_valid && t_valid, "R5 extra words still pending", {14'd0, f_valid, t_valid}, 16'h3);
        chk(exp_q.size() == 0, "R6 all expected outputs seen", W'(exp_q.size()), 16'h0);
        chk(!out_valid, "R6 no spurious output", W'(out_valid), 16'h0);
        finish_run();
    end

endmodule